// File: doc/BRIEF.md
# DMA Channel Arbiter with Channel-1 Preemption

This block decides which of six DMA channels owns the shared transfer engine. Each channel raises a request line. While the engine is free, the block grants one requester, chosen in rotating order. That channel keeps the engine until the engine reports the end of its service with a one-cycle `xfer_done` pulse. A mode input, `ch1_urgent`, lets channel 1 take the engine away from any other channel that is running.

When channel 1 takes over a running channel, the number of the displaced channel is copied into a one-deep shadow slot. When channel 1 finishes, that number is written back as the active channel, so the interrupted service carries on. The active code and the shadow code can be read together in a read-only status word. This block has no data stream. All of its pins are plain control and status levels, and none of them has a handshake.

Top module: `dma_chan_arb`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first grant, `active_code` is 0, `grant` is 0 and `status_word` is 0.
- R2: In `status_word`, bits 2:0 carry the active code and bits 6:4 carry the shadow code. Bit 3 and bits 15:7 are always 0. Code 0 means none, and code k (1 to 6) means channel k, which is driven by `chan_req[k-1]`.
- R3: `grant` is all zero when the active code is 0. Otherwise only bit k-1 is set, where k is the active code.
- R4: When the active code is 0 and some request is high at a clock edge, the active code becomes the winner of that edge. The search starts at the channel after the last channel that was started from idle, wrapping 6 to 1. After reset the search starts at channel 1.
- R5: A channel other than channel 1 that holds the engine keeps it, whatever the requests, until `xfer_done` is sampled high. The only exception is a channel-1 preemption (R7).
- R6: `xfer_done` sampled high while a channel is active sets the active code to 0 on that edge, unless R9 applies. `xfer_done` is ignored while the active code is 0.
- R7: When `ch1_urgent` and `chan_req[0]` are high, the active code is in 2 to 6 and `xfer_done` is low, the next edge makes the active code 1 and loads the old active code into the shadow.
- R8: When the engine is idle, `ch1_urgent` is high and `chan_req[0]` is high, channel 1 wins over all other requests and the shadow is loaded with 0.
- R9: When a channel 1 service that began with `ch1_urgent` high ends with `xfer_done`, the shadow value is written back to the active code on that edge, and the shadow keeps its value.
- R10: While channel 1 is active, the shadow does not change, and a further channel-1 request does not restart the service.
- R11: With `ch1_urgent` low, channel 1 takes part in the rotation like any other channel, nothing is preempted, and grants leave the shadow unchanged.
- R12: If `xfer_done` and a preempting channel-1 request arrive in the same cycle, the done wins: the active code goes to 0 (or is restored). Channel 1 is then considered from idle on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req | input | 6 | Request level per channel; bit k-1 is channel k |
| xfer_done | input | 1 | One-cycle pulse ending the active channel's service |
| ch1_urgent | input | 1 | Channel 1 preempts other channels when high |
| grant | output | 6 | One-hot grant of the active channel |
| active_code | output | 3 | Number of the active channel, 0 when idle |
| status_word | output | 16 | Read-only status: active code and shadow code |

## Verification
Every result of this block is registered. The active code, the grant and both status fields all change on the first rising edge that samples a request, done or mode change, and they are never combinational on the inputs. The bench drives inputs on the falling edge and advances its own model of the arbiter by one step. It then compares all outputs at the next falling edge, exactly one edge later. A run of directed cases covers preemption, restore, self-request, same-cycle done, and preemption from idle. After that comes a long seeded random run in which the mode bit toggles now and then.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Default geometry of the arbiter.
  localparam int unsigned DEF_NUM_CH = 6;
  localparam int unsigned DEF_STAT_W = 16;

  // Kind of state change decided for the coming edge.
  typedef enum logic [2:0] {
    EV_HOLD,
    EV_FINISH,
    EV_RESTORE,
    EV_PREEMPT,
    EV_START_URGENT,
    EV_START_ROTATE
  } arb_ev_e;

endpackage

// File: rtl/dma_arb_rr.sv
// Rotating-priority picker: returns the first requesting channel after
// the last started one, as a 1-based code (0 when nothing requests).
module dma_arb_rr #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CW     = 3
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CW-1:0]     last,
  output logic [CW-1:0]     pick
);

  logic [CW-1:0] base;
  logic [CW-1:0] idx [NUM_CH];
  logic [NUM_CH-1:0] hit;

  // A last code of 0 or NUM_CH both mean: start the search at channel 1.
  assign base = (last >= CW'(NUM_CH)) ? '0 : last;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
    logic [CW:0] sum;
    assign sum = {1'b0, base} + (CW+1)'(g);
    assign idx[g] = (sum >= (CW+1)'(NUM_CH)) ? CW'(sum - (CW+1)'(NUM_CH))
                                             : CW'(sum);
    assign hit[g] = req[idx[g]];
  end

  always_comb begin
    pick = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (hit[k]) pick = idx[k] + CW'(1);
    end
  end

endmodule

// File: rtl/dma_arb_shadow.sv
// One-deep slot for the displaced channel, plus the flag recording that
// the current channel-1 service began in urgent mode.
module dma_arb_shadow #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [CW-1:0] cap_val,
  input  logic          mark_set,
  input  logic          mark_clr,
  output logic [CW-1:0] shadow,
  output logic          urgent_entry
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow       <= '0;
      urgent_entry <= 1'b0;
    end else begin
      if (cap_en) shadow <= cap_val;
      if (mark_set)      urgent_entry <= 1'b1;
      else if (mark_clr) urgent_entry <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_arb_ctl.sv
// Next-state decision for the active channel register.
module dma_arb_ctl
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CW     = 3
) (
  input  logic [CW-1:0]     active,
  input  logic [NUM_CH-1:0] req,
  input  logic              done,
  input  logic              urgent,
  input  logic              urgent_entry,
  input  logic [CW-1:0]     shadow,
  input  logic [CW-1:0]     rr_pick,
  output logic [CW-1:0]     act_nxt,
  output logic              last_en,
  output logic              cap_en,
  output logic [CW-1:0]     cap_val,
  output logic              mark_set,
  output logic              mark_clr
);

  localparam logic [CW-1:0] CODE_CH1 = CW'(1);

  arb_ev_e ev;
  logic    idle;
  logic    ch1_call;

  assign idle     = (active == '0);
  assign ch1_call = urgent && req[0];

  // Priority: end of service, then preemption, then a fresh start.
  always_comb begin
    ev = EV_HOLD;
    if (!idle && done) begin
      ev = (active == CODE_CH1 && urgent_entry) ? EV_RESTORE : EV_FINISH;
    end else if (!idle && ch1_call && active != CODE_CH1) begin
      ev = EV_PREEMPT;
    end else if (idle && ch1_call) begin
      ev = EV_START_URGENT;
    end else if (idle && rr_pick != '0) begin
      ev = EV_START_ROTATE;
    end
  end

  always_comb begin
    act_nxt  = active;
    last_en  = 1'b0;
    cap_en   = 1'b0;
    cap_val  = '0;
    mark_set = 1'b0;
    mark_clr = 1'b0;
    case (ev)
      EV_FINISH: begin
        act_nxt  = '0;
        mark_clr = 1'b1;
      end
      EV_RESTORE: begin
        act_nxt  = shadow;
        mark_clr = 1'b1;
      end
      EV_PREEMPT: begin
        act_nxt  = CODE_CH1;
        cap_en   = 1'b1;
        cap_val  = active;
        mark_set = 1'b1;
      end
      EV_START_URGENT: begin
        act_nxt  = CODE_CH1;
        last_en  = 1'b1;
        cap_en   = 1'b1;
        cap_val  = '0;
        mark_set = 1'b1;
      end
      EV_START_ROTATE: begin
        act_nxt  = rr_pick;
        last_en  = 1'b1;
        mark_clr = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dma_chan_arb.sv
// Top level: active-channel register, rotation pointer, outputs.
module dma_chan_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned STAT_W = DEF_STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic              xfer_done,
  input  logic              ch1_urgent,
  output logic [NUM_CH-1:0] grant,
  output logic [$clog2(NUM_CH+1)-1:0] active_code,
  output logic [STAT_W-1:0] status_word
);

  localparam int unsigned CW     = $clog2(NUM_CH + 1);
  localparam int unsigned SH_LSB = CW + 1;

  logic [CW-1:0] active_q;
  logic [CW-1:0] last_q;
  logic [CW-1:0] act_nxt;
  logic [CW-1:0] rr_pick;
  logic [CW-1:0] shadow_w;
  logic [CW-1:0] cap_val;
  logic          last_en;
  logic          cap_en;
  logic          mark_set;
  logic          mark_clr;
  logic          urgent_entry_w;

  dma_arb_rr #(.NUM_CH(NUM_CH), .CW(CW)) u_rr (
    .req  (chan_req),
    .last (last_q),
    .pick (rr_pick)
  );

  dma_arb_ctl #(.NUM_CH(NUM_CH), .CW(CW)) u_ctl (
    .active       (active_q),
    .req          (chan_req),
    .done         (xfer_done),
    .urgent       (ch1_urgent),
    .urgent_entry (urgent_entry_w),
    .shadow       (shadow_w),
    .rr_pick      (rr_pick),
    .act_nxt      (act_nxt),
    .last_en      (last_en),
    .cap_en       (cap_en),
    .cap_val      (cap_val),
    .mark_set     (mark_set),
    .mark_clr     (mark_clr)
  );

  dma_arb_shadow #(.CW(CW)) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (cap_en),
    .cap_val      (cap_val),
    .mark_set     (mark_set),
    .mark_clr     (mark_clr),
    .shadow       (shadow_w),
    .urgent_entry (urgent_entry_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      last_q   <= '0;
    end else begin
      active_q <= act_nxt;
      if (last_en) last_q <= act_nxt;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_grant
    assign grant[g] = (active_q == CW'(g + 1));
  end

  assign active_code = active_q;

  always_comb begin
    status_word = '0;
    status_word[CW-1:0]        = active_q;
    status_word[SH_LSB +: CW]  = shadow_w;
  end

endmodule

// File: rtl/dma_chan_arb_chk.sv
// Property checker bound into the arbiter top.
module dma_chan_arb_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req,
  input logic              done,
  input logic              urgent,
  input logic [NUM_CH-1:0] grant,
  input logic [CW-1:0]     active,
  input logic [CW-1:0]     shadow,
  input logic              urgent_entry
);

  localparam logic [CW-1:0] C1 = CW'(1);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (active == '0 && shadow == '0));

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active <= CW'(NUM_CH)) && (shadow <= CW'(NUM_CH)));

  p_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant == '0) == (active == '0)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0 && !done && !(urgent && req[0] && active != C1))
    |=> $stable(active));

  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0 && done && !(active == C1 && urgent_entry))
    |=> (active == '0));

  p_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active > C1 && urgent && req[0] && !done)
    |=> (active == C1 && shadow == $past(active)));

  p_idle_urgent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0 && urgent && req[0]) |=> (active == C1 && shadow == '0));

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active == C1 && urgent_entry && done)
    |=> (active == $past(shadow) && $stable(shadow)));

  p_self_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active == C1 && !done) |=> ($stable(shadow) && active == C1));

  p_plain_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!urgent && active != '0 && !done) |=> ($stable(active) && $stable(shadow)));

  p_done_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active > C1 && done && urgent && req[0]) |=> (active == '0));

endmodule

bind dma_chan_arb dma_chan_arb_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (chan_req),
  .done         (xfer_done),
  .urgent       (ch1_urgent),
  .grant        (grant),
  .active       (active_q),
  .shadow       (shadow_w),
  .urgent_entry (urgent_entry_w)
);

// File: tb/dma_chan_arb_bench.sv
`timescale 1ns/1ps
module dma_chan_arb_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  chan_req = '0;
  logic        xfer_done = 1'b0;
  logic        ch1_urgent = 1'b0;
  logic [5:0]  grant;
  logic [2:0]  active_code;
  logic [15:0] status_word;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state
  logic [2:0] m_act = '0;
  logic [2:0] m_sh = '0;
  logic       m_pre = 1'b0;
  logic [2:0] m_last = '0;
  string      m_tag = "R1";

  always #4 clk = ~clk;

  dma_chan_arb u_dma_chan_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_req    (chan_req),
    .xfer_done   (xfer_done),
    .ch1_urgent  (ch1_urgent),
    .grant       (grant),
    .active_code (active_code),
    .status_word (status_word)
  );

  function automatic logic [2:0] rr_pick(input logic [5:0] r, input logic [2:0] last);
    for (int o = 1; o <= 6; o++) begin
      int c;
      c = ((int'(last) % 6) + o - 1) % 6 + 1;
      if (r[c-1]) return 3'(c);
    end
    return 3'd0;
  endfunction

  function automatic logic [5:0] onehot_of(input logic [2:0] code);
    return (code == 3'd0) ? 6'd0 : (6'd1 << (code - 3'd1));
  endfunction

  function automatic logic [15:0] status_of(input logic [2:0] a, input logic [2:0] s);
    return {9'd0, s, 1'b0, a};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [5:0] r, input logic d, input logic h);
    if (m_act != 0 && d) begin
      if (m_act == 3'd1 && m_pre) begin
        m_act = m_sh; m_tag = "R9";
      end else begin
        m_tag = (h && r[0]) ? "R12" : "R6";
        m_act = 3'd0;
      end
      m_pre = 1'b0;
    end else if (m_act != 0 && h && r[0] && m_act != 3'd1) begin
      m_sh = m_act; m_act = 3'd1; m_pre = 1'b1; m_tag = "R7";
    end else if (m_act != 0) begin
      m_tag = (m_act == 3'd1 && h && r[0]) ? "R10" : (h ? "R5" : "R11");
    end else if (h && r[0]) begin
      m_act = 3'd1; m_sh = 3'd0; m_pre = 1'b1; m_last = 3'd1; m_tag = "R8";
    end else if (r != 0) begin
      m_act = rr_pick(r, m_last); m_last = m_act; m_pre = 1'b0;
      m_tag = h ? "R4" : "R11";
    end else begin
      m_tag = d ? "R6" : "R4";
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic step(input logic [5:0] r, input logic d, input logic h);
    chan_req = r; xfer_done = d; ch1_urgent = h;
    model_step(r, d, h);
    @(negedge clk);
    check(m_tag, 16'(active_code), 16'(m_act));
    check({m_tag, " shadow"}, 16'(status_word[6:4]), 16'(m_sh));
    check("R3", 16'(grant), 16'(onehot_of(m_act)));
    check("R2", status_word, status_of(m_act, m_sh));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", 16'(active_code), 16'd0);
    check("R1", 16'(grant), 16'd0);
    check("R1", status_word, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", status_word, 16'd0);

    // Plain mode: channel 3 runs, channel 1 cannot preempt (R11), done (R6)
    step(6'b000100, 1'b0, 1'b0);
    step(6'b000001, 1'b0, 1'b0);
    step(6'b000001, 1'b0, 1'b0);
    step(6'b000000, 1'b1, 1'b0);
    step(6'b000000, 1'b1, 1'b0);  // done while idle ignored (R6)
    // Rotation after channel 3: 4, 5, 6, 1 (R4)
    for (int i = 0; i < 4; i++) begin
      step(6'b111111, 1'b0, 1'b0);
      step(6'b000000, 1'b1, 1'b0);
    end
    // Urgent mode: channel 2 runs, channel 1 preempts (R7), self call (R10),
    // done restores channel 2 (R9), then channel 2 finishes
    step(6'b000010, 1'b0, 1'b1);
    step(6'b000011, 1'b0, 1'b1);
    step(6'b000011, 1'b0, 1'b1);
    step(6'b000011, 1'b1, 1'b1);
    step(6'b000010, 1'b0, 1'b1);
    step(6'b000000, 1'b1, 1'b1);
    // Urgent from idle beats channel 6, shadow 0 (R8), done returns to 0
    step(6'b100001, 1'b0, 1'b1);
    step(6'b100000, 1'b1, 1'b1);
    step(6'b000000, 1'b0, 1'b1);
    // Channel 4 running, done and channel 1 call together (R12)
    step(6'b001000, 1'b0, 1'b1);
    step(6'b000001, 1'b1, 1'b1);
    step(6'b000001, 1'b0, 1'b1);
    step(6'b000000, 1'b1, 1'b1);

    // Seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] r;
      logic       d;
      logic       h;
      r = 6'($urandom & $urandom);
      d = ($urandom % 4) == 0;
      h = (($urandom % 16) == 0) ? ~ch1_urgent : ch1_urgent;
      step(r, d, h);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule